// File: doc/BRIEF.md
# Training-Based Sample Phase Selector

This block picks, for one receive channel, which of several oversampling clock phases should supply the received data. Upstream logic has already captured a parallel word on every internal sampling phase and moved all of those words into one common clock domain. The selector watches a calibration enable. While the enable is high, it compares the word of every phase against the training word expected for the current mode, and it keeps a per-phase record of which phases have matched on every cycle so far.

When the enable drops, the selector locks onto the phase in the middle of the passing run. It reports that phase's index, a locked flag, and from then on forwards that phase's word.

There are three modes:

- **Single-bit mode** examines five phases, a quarter bit apart, so the fifth phase repeats the first one bit later. The training word keeps the word boundary.
- **Multi-bit mode** examines eight phases and accepts an alternating pattern. It corrects skew only; word alignment is left to later logic.
- **Preset mode** skips training. It takes a fixed phase from configuration, with index 0 to 4 meaning −180°, −90°, 0°, 90° and 180°.

Top module: `phase_pick`

## Requirements
- R1: In single-bit mode a phase matches when its word equals the training word whose lower floor(W/2) bits are ones and whose remaining upper bits are zeros (bit W-1 is received first; for W=8 this is 8'h0F).
- R2: In multi-bit mode a phase matches when its word alternates in every adjacent bit pair, starting with either value (for W=8 this is 8'h55 or 8'hAA); the single-bit training word does not match.
- R3: In single-bit mode (mode 2'b00) only phases 0 to 4 can qualify; phases 5 to 7 never qualify. Multi-bit mode (mode 2'b01) uses all eight.
- R4: A phase qualifies only if it matched on every clock at which cal_en was sampled high. A lock also needs at least three such clocks.
- R5: The chosen phase is floor((lo+hi)/2). Here lo is the lowest qualifying index and hi is the last index of the unbroken qualifying run that starts at lo.
- R6: The choice is made at the first clock edge that samples cal_en low after it was high. phase_idx and locked show the result after that edge.
- R7: If no phase qualifies, or the window was shorter than three clocks, locked is low after the falling edge and phase_idx keeps its prior value.
- R8: A clock edge that samples cal_en high after it was low clears locked and discards all earlier match history.
- R9: When mode bit 1 is set (preset mode), after each edge phase_idx equals preset_sel (values 5 to 7 are treated as 4) and locked is high. cal_en is ignored.
- R10: data_out after each edge equals the word that the phase shown by phase_idx before that edge carried at that edge.
- R11: Under reset, phase_idx is 2 (the 0° phase), locked is 0 and data_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common capture-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_en | input | 1 | Calibration enable, high while training is sent |
| mode | input | 2 | 00 single-bit, 01 multi-bit, 1x preset |
| preset_sel | input | 3 | Fixed phase index for preset mode (0 = −180°, 4 = +180°) |
| ph_words | input | 8*W | Captured word of phase k at bits [k*W +: W] |
| phase_idx | output | 3 | Selected phase index |
| locked | output | 1 | High once a phase has been chosen or applied |
| data_out | output | W | Word from the selected phase, one clock later |

## Verification
Several kinds of training input are used, and each separates a different rule:

- Contiguous runs of matching phases in single-bit mode show that the middle of the run is chosen and not the first match.
- A split run shows that only the first unbroken run counts.
- A phase that fails on a single cycle in the middle of a window shows that a phase must match on every cycle.
- A window of two cycles shows the three-cycle minimum.
- Training words placed only on phases 5 to 7 show that single-bit mode limits itself to five phases.
- In multi-bit mode, the two alternating starts are mixed across cycles, and the single-bit word is offered and must be rejected.
- In preset mode, selections beyond the last phase and toggling of cal_en are applied while the mode stays fixed.
- Distinct words on every phase make data_out show which phase is routed.

// File: rtl/phase_pick_pkg.sv
package phase_pick_pkg;

    localparam int NPH       = 8;
    localparam int SINGLE_PH = 5;
    localparam int MIN_TRAIN = 3;
    localparam int PH_W      = $clog2(NPH);
    localparam int CNT_W     = $clog2(MIN_TRAIN + 1);
    localparam logic [PH_W-1:0] ZERO_DEG_PH = PH_W'(2);
    localparam logic [PH_W-1:0] LAST_PRESET = PH_W'(SINGLE_PH - 1);

    typedef enum logic [1:0] {
        MD_SINGLE = 2'd0,
        MD_MULTI  = 2'd1,
        MD_PRESET = 2'd2,
        MD_PRESET_B = 2'd3
    } mode_e;

    typedef struct packed {
        logic            found;
        logic [PH_W-1:0] idx;
    } pick_t;

    function automatic logic is_preset(input logic [1:0] md);
        return md[1];
    endfunction

    function automatic logic [PH_W-1:0] clamp_preset(input logic [PH_W-1:0] sel);
        return (sel > LAST_PRESET) ? LAST_PRESET : sel;
    endfunction

    // middle of the first unbroken run of set bits
    function automatic pick_t center_pick(input logic [NPH-1:0] pass);
        pick_t r;
        int    lo;
        int    hi;
        logic  seen;
        logic  ended;
        lo = 0;
        hi = 0;
        seen = 1'b0;
        ended = 1'b0;
        for (int i = 0; i < NPH; i++) begin
            if (!seen) begin
                if (pass[i]) begin
                    seen = 1'b1;
                    lo = i;
                    hi = i;
                end
            end else if (!ended) begin
                if (pass[i]) hi = i;
                else         ended = 1'b1;
            end
        end
        r.found = seen;
        r.idx   = PH_W'((lo + hi) / 2);
        return r;
    endfunction

endpackage

// File: rtl/phase_matcher.sv
module phase_matcher
    import phase_pick_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]     mode,
    input  logic [NPH*W-1:0] ph_words,
    output logic [NPH-1:0] match
);
    function automatic logic [W-1:0] make_sb_word();
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = (i < W / 2);
        return r;
    endfunction

    function automatic logic [W-1:0] make_alt_word();
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = (i % 2 == 0);
        return r;
    endfunction

    localparam logic [W-1:0] SB_WORD  = make_sb_word();
    localparam logic [W-1:0] ALT_WORD = make_alt_word();

    logic single_md;
    logic multi_md;
    assign single_md = (mode == MD_SINGLE);
    assign multi_md  = (mode == MD_MULTI);

    for (genvar k = 0; k < NPH; k++) begin : g_ph
        logic [W-1:0] wd;
        logic         sb_hit;
        logic         alt_hit;
        assign wd      = ph_words[k*W +: W];
        assign sb_hit  = (wd == SB_WORD);
        assign alt_hit = (wd == ALT_WORD) || (wd == ~ALT_WORD);
        if (k < SINGLE_PH) begin : g_both
            assign match[k] = (single_md && sb_hit) || (multi_md && alt_hit);
        end else begin : g_multi_only
            assign match[k] = multi_md && alt_hit;
        end
    end
endmodule

// File: rtl/pass_tracker.sv
module pass_tracker
    import phase_pick_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cal_en,
    input  logic [1:0]     mode,
    input  logic [NPH-1:0] match,
    output logic           en_q,
    output logic           en_rise,
    output logic           en_fall,
    output logic           enough,
    output logic [NPH-1:0] pass_mask
);
    logic [CNT_W-1:0] cnt_q;

    assign en_rise = cal_en && !en_q;
    assign en_fall = !cal_en && en_q;
    assign enough  = (cnt_q >= CNT_W'(MIN_TRAIN));

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            cnt_q     <= '0;
            pass_mask <= '0;
        end else begin
            en_q <= cal_en;
            if (cal_en) begin
                if (!en_q) begin
                    pass_mask <= match;
                    cnt_q     <= CNT_W'(1);
                end else begin
                    pass_mask <= pass_mask & match;
                    if (!enough) cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // R4: during a window the set of passing phases never grows
    assert_mask_shrinks_R4: assert property (@(posedge clk) disable iff (rst)
        (cal_en && en_q) |=> ((pass_mask & ~$past(pass_mask)) == '0));

    // R3: a single-bit window never records phases above the fifth
    assert_single_five_R3: assert property (@(posedge clk) disable iff (rst)
        (cal_en && mode == MD_SINGLE) |=> (pass_mask[NPH-1:SINGLE_PH] == '0));
endmodule

// File: rtl/phase_pick.sv
module phase_pick
    import phase_pick_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_en,
    input  logic [1:0]        mode,
    input  logic [2:0]        preset_sel,
    input  logic [8*W-1:0]    ph_words,
    output logic [2:0]        phase_idx,
    output logic              locked,
    output logic [W-1:0]      data_out
);
    logic [NPH-1:0] match;
    logic           en_q;
    logic           en_rise;
    logic           en_fall;
    logic           enough;
    logic [NPH-1:0] pass_mask;
    pick_t          pick;
    logic [W-1:0]   cur_word;

    phase_matcher #(.W(W)) u_match (
        .mode     (mode),
        .ph_words (ph_words),
        .match    (match)
    );

    pass_tracker u_track (
        .clk       (clk),
        .rst       (rst),
        .cal_en    (cal_en),
        .mode      (mode),
        .match     (match),
        .en_q      (en_q),
        .en_rise   (en_rise),
        .en_fall   (en_fall),
        .enough    (enough),
        .pass_mask (pass_mask)
    );

    assign pick     = center_pick(pass_mask);
    assign cur_word = ph_words[phase_idx*W +: W];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_idx <= ZERO_DEG_PH;
            locked    <= 1'b0;
            data_out  <= '0;
        end else begin
            data_out <= cur_word;
            if (is_preset(mode)) begin
                phase_idx <= clamp_preset(preset_sel);
                locked    <= 1'b1;
            end else if (en_rise) begin
                locked <= 1'b0;
            end else if (en_fall) begin
                if (enough && pick.found) begin
                    phase_idx <= pick.idx;
                    locked    <= 1'b1;
                end else begin
                    locked <= 1'b0;
                end
            end
        end
    end

    // R6: a trained lock appears only right after the enable is seen low
    assert_lock_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(locked) && !is_preset($past(mode))) |-> ($past(en_q) && !$past(cal_en)));

    // R8: restart of training drops the lock
    assert_rise_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (en_rise && !is_preset(mode)) |=> !locked);

    // R7: a failed window leaves the phase untouched and unlocked
    assert_keep_phase_R7: assert property (@(posedge clk) disable iff (rst)
        (en_fall && !is_preset(mode) && !(enough && pick.found)) |=> (!locked && $stable(phase_idx)));

    // R9: preset applies the configured phase and reports lock
    assert_preset_R9: assert property (@(posedge clk) disable iff (rst)
        is_preset(mode) |=> (locked && phase_idx == clamp_preset($past(preset_sel))));
endmodule

// File: tb/phase_pick_bench.sv
`timescale 1ns/1ps
module phase_pick_bench;
    localparam int W = 8;
    localparam int NP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cal_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [2:0] preset_sel = 3'd0;
    logic [W-1:0] w [NP];
    logic [NP*W-1:0] ph_words;
    logic [2:0] phase_idx;
    logic locked;
    logic [W-1:0] data_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R11";

    always #4 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NP; k++) ph_words[k*W +: W] = w[k];
    end

    phase_pick #(.W(W)) u_phase_pick (
        .clk(clk), .rst(rst), .cal_en(cal_en), .mode(mode),
        .preset_sel(preset_sel), .ph_words(ph_words),
        .phase_idx(phase_idx), .locked(locked), .data_out(data_out)
    );

    // ---------------- reference model ----------------
    int m_phase;
    bit m_locked;
    logic [W-1:0] m_data;
    bit m_en;
    int m_cnt;
    bit m_mask [NP];

    function automatic bit ref_match(int k);
        logic [W-1:0] sb;
        logic [W-1:0] alt;
        for (int i = 0; i < W; i++) begin
            sb[i]  = (i < W / 2);
            alt[i] = (i % 2 == 0);
        end
        if (mode == 2'b00) return (k < 5) && (w[k] == sb);
        if (mode == 2'b01) return (w[k] == alt) || (w[k] == ~alt);
        return 0;
    endfunction

    function automatic int ref_mid(output bit ok);
        int q[$];
        int first;
        ok = 0;
        first = -1;
        for (int k = 0; k < NP; k++) begin
            if (m_mask[k]) begin
                if (q.size() == 0 || q[$] == k - 1) q.push_back(k);
                else break;
            end else if (q.size() != 0) break;
        end
        if (q.size() == 0) return 0;
        ok = 1;
        first = q[0];
        return (first + q[$]) / 2;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 2; m_locked = 0; m_data = '0; m_en = 0; m_cnt = 0;
            for (int k = 0; k < NP; k++) m_mask[k] = 0;
        end else begin
            logic [W-1:0] nd;
            bit ok;
            int mid;
            nd = w[m_phase];
            if (mode[1]) begin
                m_phase = (preset_sel > 4) ? 4 : int'(preset_sel);
                m_locked = 1;
            end else if (cal_en && !m_en) begin
                m_locked = 0;
            end else if (!cal_en && m_en) begin
                mid = ref_mid(ok);
                if (ok && m_cnt >= 3) begin m_phase = mid; m_locked = 1; end
                else m_locked = 0;
            end
            if (cal_en) begin
                for (int k = 0; k < NP; k++)
                    m_mask[k] = m_en ? (m_mask[k] && ref_match(k)) : ref_match(k);
                m_cnt = m_en ? m_cnt + 1 : 1;
            end
            m_en = cal_en;
            m_data = nd;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        chk(cur_req, "phase_idx", int'(phase_idx), m_phase);
        chk(cur_req, "locked", int'(locked), int'(m_locked));
        chk("R10", "data_out", int'(data_out), int'(m_data));
    endtask

    task automatic noise();
        for (int k = 0; k < NP; k++) w[k] = 8'hC3 ^ 8'(k);
    endtask

    // hold current words for n enable-high clocks then drop the enable
    task automatic train(int n);
        cal_en = 1'b1;
        repeat (n) cyc();
        cal_en = 1'b0;
        cyc();
        cyc();
    endtask

    initial begin
        noise();
        repeat (3) cyc();
        cur_req = "R11";
        chk("R11", "reset phase", int'(phase_idx), 2);
        chk("R11", "reset locked", int'(locked), 0);
        chk("R11", "reset data", int'(data_out), 0);
        rst = 1'b0;
        cyc();

        // R1/R5: single-bit run 2..4 -> 3
        cur_req = "R5"; mode = 2'b00; noise();
        w[2] = 8'h0F; w[3] = 8'h0F; w[4] = 8'h0F;
        train(4);
        chk("R5", "run 2..4 centre", int'(phase_idx), 3);
        chk("R1", "single lock", int'(locked), 1);

        // R8: rising enable clears the lock
        cur_req = "R8"; noise(); cal_en = 1'b1; cyc(); cyc();
        chk("R8", "lock cleared", int'(locked), 0);
        cal_en = 1'b0; cyc(); cyc();
        chk("R7", "no pass keeps phase", int'(phase_idx), 3);
        chk("R7", "no pass unlocked", int'(locked), 0);

        // R5: split run 0,1 and 3 -> first run centre 0
        cur_req = "R5"; noise(); w[0] = 8'h0F; w[1] = 8'h0F; w[3] = 8'h0F;
        train(3);
        chk("R5", "split run", int'(phase_idx), 0);
        chk("R5", "split lock", int'(locked), 1);

        // R4/R7: two-cycle window is too short
        cur_req = "R7"; noise(); w[4] = 8'h0F;
        train(2);
        chk("R7", "short window phase", int'(phase_idx), 0);
        chk("R4", "short window lock", int'(locked), 0);

        // R4: phase 1 misses one cycle mid window
        cur_req = "R4"; noise(); w[0] = 8'h0F; w[1] = 8'h0F; w[2] = 8'h0F;
        cal_en = 1'b1; cyc(); cyc(); w[1] = 8'h1F; cyc(); w[1] = 8'h0F; cyc();
        cal_en = 1'b0; cyc(); cyc();
        chk("R4", "gap excludes phase 1", int'(phase_idx), 0);

        // R3: single-bit ignores phases 5..7
        cur_req = "R3"; noise(); w[5] = 8'h0F; w[6] = 8'h0F; w[7] = 8'h0F;
        train(4);
        chk("R3", "upper phases ignored", int'(locked), 0);

        // R2: multi-bit, either start, run 3..7 -> 5
        cur_req = "R2"; mode = 2'b01; noise();
        for (int k = 3; k < 8; k++) w[k] = 8'h55;
        cal_en = 1'b1; cyc();
        for (int k = 3; k < 8; k++) w[k] = 8'hAA;
        cyc(); w[4] = 8'h55; cyc(); cyc();
        cal_en = 1'b0; cyc(); cyc();
        chk("R2", "multi centre", int'(phase_idx), 5);
        chk("R2", "multi lock", int'(locked), 1);
        chk("R6", "lock after fall", int'(locked), 1);

        // R10: distinct words show routing of phase 5
        for (int k = 0; k < NP; k++) w[k] = 8'h10 + 8'(k);
        cyc(); cyc();
        chk("R10", "routed word", int'(data_out), 8'h15);

        // R2: single-bit word rejected in multi-bit mode
        cur_req = "R2"; noise(); w[1] = 8'h0F; w[2] = 8'h0F;
        train(3);
        chk("R2", "0F rejected in multi", int'(locked), 0);
        chk("R7", "multi fail keeps", int'(phase_idx), 5);

        // R9: preset
        cur_req = "R9"; mode = 2'b10; preset_sel = 3'd0; cyc(); cyc();
        chk("R9", "preset 0", int'(phase_idx), 0);
        chk("R9", "preset lock", int'(locked), 1);
        preset_sel = 3'd6; cal_en = 1'b1; cyc(); cyc();
        chk("R9", "preset clamp", int'(phase_idx), 4);
        cal_en = 1'b0; mode = 2'b11; preset_sel = 3'd1; cyc(); cyc();
        chk("R9", "preset alt code", int'(phase_idx), 1);
        chk("R9", "enable ignored", int'(locked), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule